// File: doc/BRIEF.md
# Programmable Fast-Clock Enable Divider

This block produces a single-cycle enable pulse in a fast clock domain once every D+1 fast clock cycles. D is an 8-bit divisor that is supplied from a slower clock domain. Logic downstream uses the pulse as a bit-rate strobe, so the spacing between pulses must be exact. The spacing must also stay sane while D is changing.

The fast-domain down counter is split into 2-bit slices. Registered carries link the slices, so no long borrow chain has to settle in one cycle. Terminal count is detected in two registered steps. To make up for that delay, the counter fires when it reaches 2 and not 0. Divisors 0 and 1 are too short for that pipeline, so a toggling flag produces those pulses instead. The slow domain samples the divisor on a fixed six-cycle cadence. At the same point it works out which path (small or counting) applies, then raises a flag that marks the held pair as stable. The fast domain copies the pair only while its synchronised copy of that flag is high.

Top module: `tick_rate_gen`

## Requirements
- R1: While the fast reset is asserted the enable output is low. After reset, with the divisor held at 0, the enable is high on every fast cycle.
- R2: For a steady divisor D from 2 to 255, consecutive enable pulses are exactly D+1 fast cycles apart.
- R3: A steady divisor of 0 gives a pulse on every fast cycle. A steady divisor of 1 gives a pulse on every second fast cycle.
- R4: Outside a reload, a 2-bit counter slice above the lowest one changes only if the registered carry from the slice below was set in the previous cycle.
- R5: The enable rises in the cycle after both terminal-detect registers are set: low four counter bits equal 2, and the upper counter bits equal 0.
- R6: In the cycle after each pulse, the counter holds the fast-side divisor copy, and the carry and detect registers are clear.
- R7: The fast-side divisor copy changes only in the cycle after the synchronised safe flag was high. The slow-side held divisor changes only when that flag rises. A new divisor gives its own spacing from the second pulse after it has been stable for 7 slow plus 3 fast cycles.
- R8: The path choice is the OR of divisor bits 7 to 1, computed in the slow domain. It moves across the domains together with the divisor it belongs to: 0 selects the toggle path, 1 selects the counter.
- R9: When the divisor changes from one value of 2 or more to another, no interval is shorter than the smaller of the two periods.
- R10: The slow-side safe flag stays high for exactly two slow cycles. It repeats every six slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Clock of the domain that supplies the divisor |
| slow_arst_n | input | 1 | Asynchronous active-low reset for the slow domain |
| div_i | input | 8 | Divisor D; pulse period is D+1 fast cycles |
| fast_clk | input | 1 | Fast clock; must be at least as fast as slow_clk |
| fast_arst_n | input | 1 | Asynchronous active-low reset for the fast domain |
| tick_o | output | 1 | One-cycle enable pulse, registered in the fast domain |

## Verification
A new divisor can take up to seven slow cycles to be sampled. It then needs two fast cycles to synchronise and one more to be copied, so the bench waits 40 fast cycles after each change before it expects anything. After that wait, the interval still running was timed by the old count, so the monitor skips exactly one interval and compares the ones that follow with D+1. Intervals are measured on falling fast edges, so the registered pulse is sampled half a cycle after it appears. From the moment of a change until the expected intervals are used up, every interval between two counting-path divisors is also checked against the smaller period.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  // width of one counter slice; carries between slices are registered
  localparam int unsigned SLICE_W      = 2;
  // low part of the counter compared against the firing value
  localparam int unsigned DETECT_LO_W  = 2 * SLICE_W;
  // firing value: compensates the two-cycle detection pipeline
  localparam int unsigned FIRE_VALUE   = 2;
  // width of the slow-side sampling cadence counter
  localparam int unsigned HOLD_W       = 2;
  typedef logic [HOLD_W-1:0] hold_cnt_t;
endpackage

// File: rtl/tg_reset_sync.sv
module tg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = stage_q[STAGES-1];
endmodule

// File: rtl/tg_bit_sync.sv
module tg_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tg_div_handoff.sv
module tg_div_handoff
  import tickgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] held_o,
  output logic             held_norm_o,
  output logic             safe_o
);
  hold_cnt_t        hold_cnt_q, hold_cnt_d;
  logic             safe_q, safe_d;
  logic             capture;
  logic [DIV_W-1:0] held_q;
  logic             norm_q;

  // next state: sample, keep the flag up two cycles, then wait
  always_comb begin
    hold_cnt_d = hold_cnt_q - HOLD_W'(1);
    safe_d     = safe_q;
    capture    = 1'b0;
    if (hold_cnt_q == '0) begin
      if (!safe_q) begin
        capture    = 1'b1;
        safe_d     = 1'b1;
        hold_cnt_d = HOLD_W'(1);
      end else begin
        safe_d     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt_q <= '0;
      safe_q     <= 1'b0;
    end else begin
      hold_cnt_q <= hold_cnt_d;
      safe_q     <= safe_d;
    end
  end

  // held pair, written only through the capture enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      norm_q <= 1'b0;
    end else if (capture) begin
      held_q <= div_i;
      norm_q <= |div_i[DIV_W-1:1];
    end
  end

  assign held_o      = held_q;
  assign held_norm_o = norm_q;
  assign safe_o      = safe_q;
endmodule

// File: rtl/tg_pulse_engine.sv
module tg_pulse_engine
  import tickgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] held_div_i,
  input  logic             held_norm_i,
  output logic             tick_o
);
  localparam int unsigned NSLICE = DIV_W / SLICE_W;
  localparam int unsigned LO_W   = DETECT_LO_W;

  logic [DIV_W-1:0]  cnt_q, cnt_d, cnt_step;
  logic [NSLICE-2:0] cy_q, cy_d, cy_step;
  logic [NSLICE-1:0] dec;
  logic              det_lo_q, det_lo_d;
  logic              det_hi_q, det_hi_d;
  logic              pre_q, pre_d;
  logic              tick_q, tick_d;
  logic [DIV_W-1:0]  div_q;
  logic              norm_q;

  // per-slice decrement, borrowing from the registered carry below
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    if (s == 0) begin : g_base
      assign dec[s] = 1'b1;
    end else begin : g_upper
      assign dec[s] = cy_q[s-1];
    end
    assign cnt_step[s*SLICE_W +: SLICE_W] =
      cnt_q[s*SLICE_W +: SLICE_W] - {{(SLICE_W-1){1'b0}}, dec[s]};
  end

  // carry chain, one register per slice boundary
  for (genvar c = 0; c < NSLICE - 1; c++) begin : g_carry
    if (c == 0) begin : g_first
      assign cy_step[c] = (cnt_q[0 +: SLICE_W] == '0);
    end else begin : g_next
      assign cy_step[c] = cy_q[c-1] & (cnt_q[c*SLICE_W +: SLICE_W] == '0);
    end
  end

  always_comb begin
    cnt_d    = cnt_step;
    cy_d     = cy_step;
    det_lo_d = (cnt_q[LO_W-1:0] == LO_W'(FIRE_VALUE));
    det_hi_d = (cnt_q[DIV_W-1:LO_W] == '0);
    tick_d   = (det_lo_q & det_hi_q) | pre_q;
    pre_d    = ~norm_q & (~pre_q | ~div_q[0]);
    if (tick_q) begin
      cnt_d    = div_q;
      cy_d     = '0;
      det_lo_d = 1'b0;
      det_hi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cy_q     <= '0;
      det_lo_q <= 1'b0;
      det_hi_q <= 1'b0;
      pre_q    <= 1'b1;
      tick_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      cy_q     <= cy_d;
      det_lo_q <= det_lo_d;
      det_hi_q <= det_hi_d;
      pre_q    <= pre_d;
      tick_q   <= tick_d;
    end
  end

  // divisor copy, enabled only by the synchronised safe flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      norm_q <= 1'b0;
    end else if (load_i) begin
      div_q  <= held_div_i;
      norm_q <= held_norm_i;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             slow_clk,
  input  logic             slow_arst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fast_clk,
  input  logic             fast_arst_n,
  output logic             tick_o
);
  logic             slow_rst_n;
  logic             fast_rst_n;
  logic [DIV_W-1:0] held_div;
  logic             held_norm;
  logic             safe_slow;
  logic             safe_fast;

  tg_reset_sync #(.STAGES(SYNC_STAGES)) u_slow_rst (
    .clk     (slow_clk),
    .arst_n  (slow_arst_n),
    .rst_n_o (slow_rst_n)
  );

  tg_reset_sync #(.STAGES(SYNC_STAGES)) u_fast_rst (
    .clk     (fast_clk),
    .arst_n  (fast_arst_n),
    .rst_n_o (fast_rst_n)
  );

  tg_div_handoff #(.DIV_W(DIV_W)) u_handoff (
    .clk         (slow_clk),
    .rst_n       (slow_rst_n),
    .div_i       (div_i),
    .held_o      (held_div),
    .held_norm_o (held_norm),
    .safe_o      (safe_slow)
  );

  tg_bit_sync #(.STAGES(SYNC_STAGES)) u_safe_sync (
    .clk   (fast_clk),
    .rst_n (fast_rst_n),
    .d_i   (safe_slow),
    .q_o   (safe_fast)
  );

  tg_pulse_engine #(.DIV_W(DIV_W)) u_engine (
    .clk         (fast_clk),
    .rst_n       (fast_rst_n),
    .load_i      (safe_fast),
    .held_div_i  (held_div),
    .held_norm_i (held_norm),
    .tick_o      (tick_o)
  );
endmodule

// File: rtl/tick_rate_gen_chk.sv
module tg_engine_chk
  import tickgen_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            load_i,
  input logic [DIV_W-1:0]                cnt_q,
  input logic [DIV_W/SLICE_W-2:0]        cy_q,
  input logic                            det_lo_q,
  input logic                            det_hi_q,
  input logic                            tick_q,
  input logic [DIV_W-1:0]                div_q,
  input logic                            norm_q
);
  localparam int unsigned NSLICE = DIV_W / SLICE_W;

  // R5
  fire_on_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_lo_q && det_hi_q) |=> tick_q);

  // R6
  reload_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> (cnt_q == $past(div_q)) && (cy_q == '0) && !det_lo_q && !det_hi_q);

  // R4
  for (genvar s = 1; s < NSLICE; s++) begin : g_hold
    slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_q && !cy_q[s-1]) |=> $stable(cnt_q[s*SLICE_W +: SLICE_W]));
  end

  // R7
  copy_on_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(load_i));

  // R8
  mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_q == (div_q[DIV_W-1:1] != '0));
endmodule

module tg_handoff_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             safe_q,
  input logic [DIV_W-1:0] held_q,
  input logic             norm_q
);
  // R10
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(safe_q) |=> safe_q);

  // R10
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_q && $past(safe_q)) |=> !safe_q);

  // R7
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_q) |-> $rose(safe_q));

  // R8
  mode_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_q == (held_q[DIV_W-1:1] != '0));
endmodule

bind tg_pulse_engine tg_engine_chk #(.DIV_W(DIV_W)) i_engine_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .cnt_q    (cnt_q),
  .cy_q     (cy_q),
  .det_lo_q (det_lo_q),
  .det_hi_q (det_hi_q),
  .tick_q   (tick_q),
  .div_q    (div_q),
  .norm_q   (norm_q)
);

bind tg_div_handoff tg_handoff_chk #(.DIV_W(DIV_W)) i_handoff_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .safe_q (safe_q),
  .held_q (held_q),
  .norm_q (norm_q)
);

// File: tb/test_tick_rate_gen.sv
module test_tick_rate_gen;
  logic       fast_clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       fast_arst_n = 1'b0;
  logic       slow_arst_n = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last = 0;
  bit have_last = 1'b0;
  int skip = 0;
  bit floor_en = 1'b0;
  int floor_v = 0;
  int cur = 0;
  bit finished = 1'b0;
  int exp_q[$];
  string tag_q[$];

  localparam int SETTLE = 40;
  localparam int LIMIT  = 190000;

  tick_rate_gen i_tick_rate_gen (
    .slow_clk    (slow_clk),
    .slow_arst_n (slow_arst_n),
    .div_i       (div_i),
    .fast_clk    (fast_clk),
    .fast_arst_n (fast_arst_n),
    .tick_o      (tick_o)
  );

  always #5 fast_clk = ~fast_clk;
  initial begin
    #2;
    forever #16 slow_clk = ~slow_clk;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d, expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: measures pulse spacing and pops expected intervals
  always @(negedge fast_clk) begin
    int iv;
    cyc++;
    if (fast_arst_n && tick_o) begin
      if (have_last) begin
        iv = cyc - last;
        if (floor_en) begin
          checks++;
          if (iv < floor_v) begin
            errors++;
            $display("FAIL R9: interval %0d, expected at least %0d", iv, floor_v);
          end
        end
        if (skip > 0) begin
          skip--;
        end else if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), "interval", iv, exp_q.pop_front());
        end
      end
      have_last = 1'b1;
      last = cyc;
    end
  end

  // driver: change divisor, wait for hand-off, queue expected spacing
  task automatic apply(input int nd, input int n, input string tag);
    int old;
    old = cur;
    @(negedge fast_clk); #1;
    floor_en = (old >= 2) && (nd >= 2);
    floor_v  = ((old < nd) ? old : nd) + 1;
    div_i = 8'(nd);
    cur = nd;
    repeat (SETTLE) @(negedge fast_clk);
    #1;
    skip = 1;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(nd + 1);
      tag_q.push_back(tag);
    end
    while (skip != 0 || exp_q.size() != 0) @(negedge fast_clk);
    #1;
    floor_en = 1'b0;
  endtask

  initial begin
    // R1: output quiet in reset
    for (int k = 0; k < 5; k++) begin
      @(negedge fast_clk);
      check("R1", "tick during reset", int'(tick_o), 0);
    end
    @(negedge fast_clk); #1;
    slow_arst_n = 1'b1;
    fast_arst_n = 1'b1;
    // R1: divisor 0 after reset pulses every cycle
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(1);
      tag_q.push_back("R1");
    end
    while (exp_q.size() != 0) @(negedge fast_clk);
    // sweep of every divisor (R2, R3, R4, R5)
    for (int d = 0; d < 256; d++) begin
      if (d < 2)       apply(d, 2, "R3");
      else if (d == 2) apply(d, 2, "R5");
      else if (d < 16) apply(d, 2, "R2");
      else             apply(d, (d < 128) ? 2 : 1, "R4");
    end
    // directed changes
    apply(3, 2, "R9");
    apply(200, 2, "R9");
    apply(1, 3, "R8");
    apply(2, 3, "R8");
    apply(0, 3, "R7");
    apply(37, 3, "R6");
    apply(36, 3, "R7");
    report();
  end

  // watchdog
  initial begin
    while (cyc < LIMIT) @(negedge fast_clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2: watchdog at cycle %0d, expected end before %0d", cyc, LIMIT);
      report();
    end
  end
endmodule